// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time-slot interchange between two time-division multiplexed ports, called the local port and the backplane port. Each port carries a fixed number of parallel streams. Each stream holds one byte channel per slot. Once per frame a frame-start strobe marks slot 0, and every following clock cycle carries the next slot. Each port's received bytes go into its own frame-buffered data memory.

Each output port has a connection memory with one entry per output stream and channel. For each output channel, the entry picks one of three outputs:
- a switched byte from either data memory,
- a constant message byte held in the entry,
- a disabled (high-impedance) channel.

A host writes entries through a single-cycle write strobe. A new entry becomes active at the next frame start, so an output frame never mixes old and new entries. All four port-to-port paths run at the same time with a constant delay of two frames. Because the source-port flag and the stream field together address every input stream, the two ports together also act as one square switch of twice the per-port size.

A small synchroniser state machine tracks framing. It has two states:
- HUNT: no valid framing. This is the state after reset.
- RUN: the block is aligned to the frame.

It takes three transitions:
- HUNT to RUN on a frame-start strobe.
- RUN to RUN either on a frame start (realignment to slot 0) or on a slot advance.
- RUN to HUNT (loss of framing) when the last slot of a frame is followed by a cycle without a frame start.

Top module: `tsi_switch`

## Requirements
- R1: Bit 8 of an entry selects the data memory: 0 reads the local memory, 1 reads the backplane memory. Bit 2 gives the source stream and bits 1:0 give the source channel. Paths from local to local, local to backplane, backplane to local and backplane to backplane all work in the same frames.
- R2: In connection mode (bit 10 clear, bit 9 set), the output byte equals the byte received on the selected stream and channel two frames earlier. This holds for every source and destination channel.
- R3: When entry bit 10 (message) and bit 9 (enable) are both set, the output byte is entry bits 7:0.
- R4: When entry bit 9 is clear, the channel's enable output is 0 and its data byte is 0x00.
- R5: After reset, every connection entry is zero, so every output channel is disabled with data 0x00.
- R6: A host write in any cycle takes effect from the first frame-start cycle after it. Output slots before that frame still use the previous entry.
- R7: The cycle that carries the frame-start strobe is slot 0, and each later cycle is the next slot. The output for slot s appears on the clock edge that ends the cycle in which input slot s is presented.
- R8: In HUNT, and in the cycle that drops RUN after the last slot passes without a frame start, no slot is processed. All outputs then become disabled with data 0x00 on the next edge.
- R9: Switched bytes that come from frames before the first two received frames read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks slot 0 of a frame |
| loc_in | input | NSTREAM*8 | Local input bytes, stream k at bits 8k+7:8k |
| bp_in | input | NSTREAM*8 | Backplane input bytes, same layout |
| cfg_we | input | 1 | Connection entry write strobe |
| cfg_port | input | 1 | Target output port: 0 local, 1 backplane |
| cfg_stream | input | SW | Target output stream |
| cfg_chan | input | CW | Target output channel |
| cfg_data | input | EW | Entry: bit EW-1 message, EW-2 enable, EW-3 source port, low bits payload |
| loc_out | output | NSTREAM*8 | Local output bytes |
| loc_out_en | output | NSTREAM | Local per-stream drive enable for the current channel |
| bp_out | output | NSTREAM*8 | Backplane output bytes |
| bp_out_en | output | NSTREAM | Backplane per-stream drive enable |

## Verification
Every cycle, the assertions check four things:
- The active connection entries change only in a frame-start cycle.
- A cycle without a slot leaves all outputs disabled on the next edge.
- A disabled channel carries a zero byte.
- The synchroniser drops to HUNT when a frame overruns, and the write bank never equals the read bank.

The two-frame delay, the choice of source memory, message bytes and the deferred effect of host writes can only be shown by the bench. It keeps its own history of received frames and its own copy of the connection entries, and compares every output channel of every slot against them. Those scenarios also cover:
- slot alignment, through a distinct message byte per channel,
- the zero bytes of the first two frames,
- recovery after framing is lost.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } sync_state_t;

    localparam logic PORT_LOCAL = 1'b0;
    localparam logic PORT_BACK  = 1'b1;

    function automatic logic [1:0] bank_next(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction
endpackage

// File: rtl/tsi_frame_fsm.sv
module tsi_frame_fsm
    import tsi_pkg::*;
#(
    parameter int NCHAN = 4,
    localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    output logic          slot_valid,
    output logic [CW-1:0] slot,
    output logic [1:0]    wbank,
    output logic [1:0]    rbank
);
    localparam logic [CW-1:0] LAST = CW'(NCHAN - 1);

    sync_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [1:0]    bank_q;

    // next-state and slot decode
    always_comb begin
        state_d    = state_q;
        slot_valid = 1'b0;
        slot       = cnt_q;
        unique case (state_q)
            ST_HUNT: begin
                if (frame_start) begin
                    state_d    = ST_RUN;
                    slot_valid = 1'b1;
                    slot       = '0;
                end
            end
            ST_RUN: begin
                if (frame_start) begin
                    slot_valid = 1'b1;
                    slot       = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_HUNT;
                end else begin
                    slot_valid = 1'b1;
                    slot       = cnt_q + CW'(1);
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    assign wbank = frame_start ? bank_next(bank_q) : bank_q;
    assign rbank = bank_next(wbank);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            bank_q  <= 2'd2;
        end else begin
            state_q <= state_d;
            if (slot_valid) cnt_q <= slot;
            if (frame_start) bank_q <= wbank;
        end
    end

    p_gap_to_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q == LAST && !frame_start) |=> (state_q == ST_HUNT));

    p_bank_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q != 2'd3);

    p_read_not_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rbank != wbank);
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
    parameter int NSTREAM = 2,
    parameter int NCHAN   = 4,
    localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int FW = NSTREAM * NCHAN * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CW-1:0]        slot,
    input  logic [1:0]           wbank,
    input  logic [1:0]           rbank,
    input  logic [NSTREAM*8-1:0] din,
    output logic [FW-1:0]        rd_frame
);
    logic [FW-1:0] bank_q [3];

    for (genvar b = 0; b < 3; b++) begin : g_bank
        for (genvar s = 0; s < NSTREAM; s++) begin : g_str
            for (genvar c = 0; c < NCHAN; c++) begin : g_ch
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        bank_q[b][(s*NCHAN+c)*8 +: 8] <= 8'h00;
                    else if (we && wbank == 2'(b) && slot == CW'(c))
                        bank_q[b][(s*NCHAN+c)*8 +: 8] <= din[s*8 +: 8];
                end
            end
        end
    end

    always_comb begin
        unique case (rbank)
            2'd0:    rd_frame = bank_q[0];
            2'd1:    rd_frame = bank_q[1];
            default: rd_frame = bank_q[2];
        endcase
    end
endmodule

// File: rtl/tsi_out_port.sv
module tsi_out_port #(
    parameter int NSTREAM = 2,
    parameter int NCHAN   = 4,
    localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int SW = (NSTREAM > 1) ? $clog2(NSTREAM) : 1,
    localparam int PW = (SW + CW > 8) ? SW + CW : 8,
    localparam int EW = PW + 3,
    localparam int FW = NSTREAM * NCHAN * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 swap,
    input  logic                 slot_valid,
    input  logic [CW-1:0]        slot,
    input  logic                 cfg_we,
    input  logic [SW-1:0]        cfg_stream,
    input  logic [CW-1:0]        cfg_chan,
    input  logic [EW-1:0]        cfg_data,
    input  logic [FW-1:0]        loc_frame,
    input  logic [FW-1:0]        bp_frame,
    output logic [NSTREAM*8-1:0] out_data,
    output logic [NSTREAM-1:0]   out_en
);
    localparam int B_MSG = EW - 1;
    localparam int B_EN  = EW - 2;
    localparam int B_SRC = EW - 3;

    logic [NSTREAM-1:0][NCHAN-1:0][EW-1:0] sh_q, act_q;
    logic [NSTREAM*8-1:0] data_d;
    logic [NSTREAM-1:0]   en_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            act_q <= '0;
        end else begin
            if (cfg_we && int'(cfg_stream) < NSTREAM && int'(cfg_chan) < NCHAN)
                sh_q[cfg_stream][cfg_chan] <= cfg_data;
            if (swap) act_q <= sh_q;
        end
    end

    for (genvar k = 0; k < NSTREAM; k++) begin : g_out
        logic [EW-1:0] ent;
        logic [SW-1:0] src_s;
        logic [CW-1:0] src_c;
        logic [7:0]    sw_byte;

        assign ent   = swap ? sh_q[k][slot] : act_q[k][slot];
        assign src_c = ent[CW-1:0];
        assign src_s = ent[CW +: SW];

        always_comb begin
            sw_byte = 8'h00;
            if (int'(src_s) < NSTREAM && int'(src_c) < NCHAN) begin
                if (ent[B_SRC] == tsi_pkg::PORT_BACK)
                    sw_byte = bp_frame[(int'(src_s)*NCHAN + int'(src_c))*8 +: 8];
                else
                    sw_byte = loc_frame[(int'(src_s)*NCHAN + int'(src_c))*8 +: 8];
            end
            en_d[k]          = slot_valid && ent[B_EN];
            data_d[k*8 +: 8] = !en_d[k] ? 8'h00 : (ent[B_MSG] ? ent[7:0] : sw_byte);
        end

        p_off_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |-> (out_data[k*8 +: 8] == 8'h00));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
            out_en   <= '0;
        end else begin
            out_data <= data_d;
            out_en   <= en_d;
        end
    end

    p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(act_q));

    p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |=> (out_en == '0));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int NSTREAM = 2,
    parameter int NCHAN   = 4,
    localparam int CW = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int SW = (NSTREAM > 1) ? $clog2(NSTREAM) : 1,
    localparam int PW = (SW + CW > 8) ? SW + CW : 8,
    localparam int EW = PW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic [NSTREAM*8-1:0] loc_in,
    input  logic [NSTREAM*8-1:0] bp_in,
    input  logic                 cfg_we,
    input  logic                 cfg_port,
    input  logic [SW-1:0]        cfg_stream,
    input  logic [CW-1:0]        cfg_chan,
    input  logic [EW-1:0]        cfg_data,
    output logic [NSTREAM*8-1:0] loc_out,
    output logic [NSTREAM-1:0]   loc_out_en,
    output logic [NSTREAM*8-1:0] bp_out,
    output logic [NSTREAM-1:0]   bp_out_en
);
    localparam int FW = NSTREAM * NCHAN * 8;

    logic          slot_valid;
    logic [CW-1:0] slot;
    logic [1:0]    wbank, rbank;
    logic [FW-1:0] loc_frame, bp_frame;

    tsi_frame_fsm #(.NCHAN(NCHAN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .slot_valid(slot_valid), .slot(slot), .wbank(wbank), .rbank(rbank)
    );

    tsi_data_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_loc_mem (
        .clk(clk), .rst_n(rst_n), .we(slot_valid), .slot(slot),
        .wbank(wbank), .rbank(rbank), .din(loc_in), .rd_frame(loc_frame)
    );

    tsi_data_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_bp_mem (
        .clk(clk), .rst_n(rst_n), .we(slot_valid), .slot(slot),
        .wbank(wbank), .rbank(rbank), .din(bp_in), .rd_frame(bp_frame)
    );

    tsi_out_port #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_loc_out (
        .clk(clk), .rst_n(rst_n), .swap(frame_start), .slot_valid(slot_valid),
        .slot(slot), .cfg_we(cfg_we && cfg_port == tsi_pkg::PORT_LOCAL),
        .cfg_stream(cfg_stream), .cfg_chan(cfg_chan), .cfg_data(cfg_data),
        .loc_frame(loc_frame), .bp_frame(bp_frame),
        .out_data(loc_out), .out_en(loc_out_en)
    );

    tsi_out_port #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_bp_out (
        .clk(clk), .rst_n(rst_n), .swap(frame_start), .slot_valid(slot_valid),
        .slot(slot), .cfg_we(cfg_we && cfg_port == tsi_pkg::PORT_BACK),
        .cfg_stream(cfg_stream), .cfg_chan(cfg_chan), .cfg_data(cfg_data),
        .loc_frame(loc_frame), .bp_frame(bp_frame),
        .out_data(bp_out), .out_en(bp_out_en)
    );
endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
    localparam int NS = 2;
    localparam int NC = 4;
    localparam int EW = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_start = 1'b0;
    logic [NS*8-1:0] loc_in = '0, bp_in = '0;
    logic            cfg_we = 1'b0, cfg_port = 1'b0;
    logic [0:0]      cfg_stream = '0;
    logic [1:0]      cfg_chan = '0;
    logic [EW-1:0]   cfg_data = '0;
    logic [NS*8-1:0] loc_out, bp_out;
    logic [NS-1:0]   loc_out_en, bp_out_en;

    always #4 clk = ~clk;

    tsi_switch #(.NSTREAM(NS), .NCHAN(NC)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .loc_in(loc_in), .bp_in(bp_in), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_stream(cfg_stream), .cfg_chan(cfg_chan), .cfg_data(cfg_data),
        .loc_out(loc_out), .loc_out_en(loc_out_en),
        .bp_out(bp_out), .bp_out_en(bp_out_en)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    logic [7:0]    hist [0:63][0:1][0:NS-1][0:NC-1];
    logic [EW-1:0] sh   [0:1][0:NS-1][0:NC-1];
    logic [EW-1:0] act  [0:1][0:NS-1][0:NC-1];
    int fr = -1;
    int slot_m = 0;
    bit wrote_any = 0;

    logic [7:0] exp_d [0:1][0:NS-1];
    bit         exp_e [0:1][0:NS-1];
    string      exp_t [0:1][0:NS-1];

    task automatic check_outputs();
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < NS; k++) begin
                logic [7:0] d;
                bit e;
                d = p ? bp_out[k*8 +: 8] : loc_out[k*8 +: 8];
                e = p ? bp_out_en[k] : loc_out_en[k];
                checks++;
                if (d !== exp_d[p][k] || e !== exp_e[p][k]) begin
                    failures++;
                    $display("FAIL %s port%0d stream%0d: en=%0d data=%02h expected en=%0d data=%02h",
                             exp_t[p][k], p, k, e, d, exp_e[p][k], exp_d[p][k]);
                end
            end
        end
    endtask

    // expected output for destination port p, stream k, channel c
    task automatic predict(input int p, input int k, input int c);
        logic [EW-1:0] e;
        int sp, ss, sc;
        e = act[p][k][c];
        if (!e[9]) begin
            exp_e[p][k] = 0; exp_d[p][k] = 8'h00;
            exp_t[p][k] = wrote_any ? "R4" : "R5";
        end else if (e[10]) begin
            exp_e[p][k] = 1; exp_d[p][k] = e[7:0];
            exp_t[p][k] = "R3,R7";
        end else begin
            sp = int'(e[8]); ss = int'(e[2]); sc = int'(e[1:0]);
            exp_e[p][k] = 1;
            if (fr < 2) begin
                exp_d[p][k] = 8'h00; exp_t[p][k] = "R9";
            end else begin
                exp_d[p][k] = hist[fr-2][sp][ss][sc];
                exp_t[p][k] = (sp != p) ? "R1,R2" : "R2";
            end
        end
        if (act[p][k][c] != sh[p][k][c]) exp_t[p][k] = "R6";
    endtask

    // one cycle: check the previous slot, drive this one, model it
    task automatic step(input bit fs, input bit valid, input bit we,
                        input bit wp, input int ws, input int wc, input logic [EW-1:0] wd);
        check_outputs();
        frame_start = fs;
        loc_in = NS*8'($urandom);
        bp_in  = NS*8'($urandom);
        cfg_we = we; cfg_port = wp; cfg_stream = 1'(ws); cfg_chan = 2'(wc); cfg_data = wd;
        if (valid) begin
            if (fs) begin
                fr++;
                slot_m = 0;
                act = sh;
            end else begin
                slot_m++;
            end
            for (int s = 0; s < NS; s++) begin
                hist[fr][0][s][slot_m] = loc_in[s*8 +: 8];
                hist[fr][1][s][slot_m] = bp_in[s*8 +: 8];
            end
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < NS; k++) predict(p, k, slot_m);
        end else begin
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < NS; k++) begin
                    exp_e[p][k] = 0; exp_d[p][k] = 8'h00; exp_t[p][k] = "R8";
                end
        end
        if (we) begin
            sh[int'(wp)][ws][wc] = wd;
            wrote_any = 1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input int f);
        for (int c = 0; c < NC; c++) begin
            bit we = 0, wp = 0;
            int ws = 0, wc = 0;
            logic [EW-1:0] wd = '0;
            if (f == 0) begin
                we = 1;
                case (c)
                    0: begin wp = 0; ws = 0; wc = 0; wd = {3'b110, 8'hA5}; end
                    1: begin wp = 1; ws = 1; wc = 3; wd = {3'b010, 8'h01}; end
                    2: begin wp = 0; ws = 1; wc = 2; wd = {3'b011, 8'h04}; end
                    default: begin wp = 1; ws = 0; wc = 1; wd = {3'b011, 8'h02}; end
                endcase
            end else if (f == 1) begin
                we = 1; wp = 0; ws = 1; wc = c; wd = {3'b110, 8'(8'h10 + c)};
            end else if (f == 5 && c == 0) begin
                we = 1; wp = 0; ws = 0; wc = 3; wd = {3'b110, 8'h3C};
            end else if (f >= 2 && f < 28 && ($urandom % 2) == 1) begin
                we = 1; wp = 1'($urandom); ws = int'($urandom % NS); wc = int'($urandom % NC);
                wd = {1'($urandom), 1'(($urandom % 4) != 0), 1'($urandom), 8'($urandom)};
            end
            step(c == 0, 1, we, wp, ws, wc, wd);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < NS; k++) begin
                exp_e[p][k] = 0; exp_d[p][k] = 8'h00; exp_t[p][k] = "R5";
                for (int c = 0; c < NC; c++) begin sh[p][k][c] = '0; act[p][k][c] = '0; end
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // before any frame start: HUNT, no slots (R8); first check covers R5
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, '0);
        for (int f = 0; f < 30; f++) run_frame(f);
        // framing lost: slots stop, outputs go dark (R8)
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, '0);
        for (int f = 30; f < 33; f++) run_frame(f);
        step(0, 0, 0, 0, 0, 0, '0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule